// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block steps a small accumulator machine through one instruction at a time. Each instruction is 32 bits long and sits in two consecutive 16-bit memory words. The block reads both words into an instruction register and splits them into fields. It then reads the memory operand into a data register and copies the chosen general-purpose register into the accumulator. The next step combines the two and writes the result back into the accumulator. Every step takes one clock cycle. The memory port is synchronous: read data appears in the cycle after the request.

The block owns the program counter, the memory address register, the instruction register, the data register, the accumulator and a three-bit flag register. It reads from a 16-entry register file, which sits outside the block, through a combinational read port. The operation being executed is shown on a three-bit ALU code output. An instruction with an unknown operation code, or with an addressing mode other than direct, raises a one-cycle illegal pulse. Fetching then restarts at the following instruction, and the accumulator and flags keep their values.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `acc`, `flags`, `alu_op`, `mem_rd`, `instr_done` and `instr_illegal` are all zero. The first fetch reads address `RESET_PC` (0 by default).
- R2: Every memory read is a `mem_rd` pulse that lasts one cycle. Counting cycle 1 as the first cycle of an instruction, the word at PC is requested in cycle 1 and the word at PC+1 in cycle 3. Read data is taken from `mem_rdata` in the cycle after the request.
- R3: The first word carries the operation code in bits 15..11, the mode in bits 10..8, the register index in bits 7..4 and address bits 19..16 in bits 3..0. The second word holds address bits 15..0.
- R4: For a legal instruction, `rf_idx` shows the register index from cycle 6. In cycle 6 the operand is requested at the full 20-bit direct address.
- R5: Operation codes 0 to 5 are legal when the mode is 0. They compute R+M, R-M, R AND M, R OR M, R XOR M and M (move), where R is the register operand and M is the memory operand. `acc` holds R in cycles 7 and 8. In cycle 9 `acc` holds the result, `instr_done` pulses for one cycle and `alu_op` equals bits 2..0 of the operation code.
- R6: `flags` is written only together with a result. Bit 0 is set when the result is zero and bit 1 is result bit 15. Bit 2 is the carry out for add, the borrow (R < M) for subtract, and 0 for the other operations.
- R7: An operation code of 6 or above, or a mode other than 0, raises `instr_illegal` in cycle 6. Such an instruction leaves `acc` and `flags` unchanged, makes no operand read, and the next fetch starts in cycle 7.
- R8: The program counter advances by two per instruction, whether the instruction is legal or not.
- R9: `instr_done` and `instr_illegal` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 20 | Memory address register |
| mem_rd | output | 1 | Read request; data is expected on the next cycle |
| mem_rdata | input | 16 | Read data from memory |
| rf_idx | output | 4 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| alu_op | output | 3 | Code of the operation being executed |
| acc | output | 16 | Accumulator |
| flags | output | 3 | {carry, sign, zero} |
| instr_done | output | 1 | One-cycle pulse when a result is written |
| instr_illegal | output | 1 | One-cycle pulse when an illegal instruction is rejected |

## Verification
If the sequencer enters a wrong state, its next read request moves to the wrong cycle or the wrong address on `mem_addr`. The reference model sees this within one cycle, because it predicts `mem_rd` and `mem_addr` on every clock. A wrong decode, a wrong operand latch or a wrong ALU function shows up in `acc` in cycle 7 or cycle 9 of the same instruction. A program counter that advances wrongly is caught at the next instruction's first fetch address. Broken illegal handling shows up as an `acc` or `flags` change, or as a stray operand read, before the next fetch begins.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    S_FH_MAR,
    S_FH_RD,
    S_FH_IR,
    S_FL_RD,
    S_FL_IR,
    S_DEC,
    S_OP_RD,
    S_OP_DR,
    S_EXE
  } seq_state_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_PASS = 3'd5
  } alu_op_e;

  localparam int NUM_LEGAL_OPS = 6;
  localparam int MODE_DIRECT   = 0;

endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter int RIDX_W = 4,
  parameter int OPC_W  = 5,
  parameter int MODE_W = 3
) (
  input  logic [DATA_W-1:0] ir_hi,
  input  logic [DATA_W-1:0] ir_lo,
  output alu_op_e           op,
  output logic [RIDX_W-1:0] ridx,
  output logic [ADDR_W-1:0] maddr,
  output logic              legal
);
  localparam int IW      = 2 * DATA_W;
  localparam int OPC_LSB = IW - OPC_W;
  localparam int MOD_LSB = OPC_LSB - MODE_W;
  localparam int REG_LSB = MOD_LSB - RIDX_W;

  logic [IW-1:0]     word;
  logic [OPC_W-1:0]  opc;
  logic [MODE_W-1:0] mode;

  assign word  = {ir_hi, ir_lo};
  assign opc   = word[IW-1:OPC_LSB];
  assign mode  = word[OPC_LSB-1:MOD_LSB];
  assign ridx  = word[MOD_LSB-1:REG_LSB];
  assign maddr = word[ADDR_W-1:0];
  assign op    = alu_op_e'(opc[2:0]);
  assign legal = (opc < OPC_W'(NUM_LEGAL_OPS)) && (mode == MODE_W'(MODE_DIRECT));

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         carry
);
  logic [W:0] wide;

  always_comb begin
    wide  = '0;
    res   = '0;
    carry = 1'b0;
    case (op)
      ALU_ADD: begin
        wide  = {1'b0, a} + {1'b0, b};
        res   = wide[W-1:0];
        carry = wide[W];
      end
      ALU_SUB: begin
        wide  = {1'b0, a} - {1'b0, b};
        res   = wide[W-1:0];
        carry = wide[W];
      end
      ALU_AND:  res = a & b;
      ALU_OR:   res = a | b;
      ALU_XOR:  res = a ^ b;
      ALU_PASS: res = b;
      default:  res = '0;
    endcase
  end

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_acc_rf,
  input  logic [W-1:0] rf_data,
  input  logic         ld_dr,
  input  logic [W-1:0] mem_data,
  input  logic         ld_res,
  input  logic [W-1:0] res,
  input  logic         carry,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] dr_q,
  output logic [2:0]   flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      dr_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ld_dr) dr_q <= mem_data;
      if (ld_acc_rf) begin
        acc_q <= rf_data;
      end else if (ld_res) begin
        acc_q   <= res;
        flags_q <= {carry, res[W-1], (res == '0)};
      end
    end
  end

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 20,
  parameter int RIDX_W   = 4,
  parameter int OPC_W    = 5,
  parameter int MODE_W   = 3,
  parameter int RESET_PC = 0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [RIDX_W-1:0] rf_idx,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [2:0]        alu_op,
  output logic [DATA_W-1:0] acc,
  output logic [2:0]        flags,
  output logic              instr_done,
  output logic              instr_illegal
);
  seq_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic              rd_q;
  logic [DATA_W-1:0] ir_hi;
  logic [DATA_W-1:0] ir_lo;
  alu_op_e           op_q;
  logic              done_q;
  logic              ill_q;

  alu_op_e           dec_op;
  logic [RIDX_W-1:0] dec_ridx;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_legal;

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] dr_q;
  logic [2:0]        flags_q;
  logic [DATA_W-1:0] alu_res;
  logic              alu_carry;

  acc_seq_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W),
    .OPC_W(OPC_W), .MODE_W(MODE_W)
  ) u_dec (
    .ir_hi (ir_hi),
    .ir_lo (ir_lo),
    .op    (dec_op),
    .ridx  (dec_ridx),
    .maddr (dec_addr),
    .legal (dec_legal)
  );

  acc_seq_alu #(.W(DATA_W)) u_alu (
    .op    (op_q),
    .a     (acc_q),
    .b     (dr_q),
    .res   (alu_res),
    .carry (alu_carry)
  );

  acc_seq_dpath #(.W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ld_acc_rf (state == S_OP_RD),
    .rf_data   (rf_rdata),
    .ld_dr     (state == S_OP_DR),
    .mem_data  (mem_rdata),
    .ld_res    (state == S_EXE),
    .res       (alu_res),
    .carry     (alu_carry),
    .acc_q     (acc_q),
    .dr_q      (dr_q),
    .flags_q   (flags_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_FH_MAR;
      pc     <= ADDR_W'(RESET_PC);
      mar    <= '0;
      rd_q   <= 1'b0;
      ir_hi  <= '0;
      ir_lo  <= '0;
      op_q   <= ALU_ADD;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      case (state)
        S_FH_MAR: begin
          mar   <= pc;
          rd_q  <= 1'b1;
          state <= S_FH_RD;
        end
        S_FH_RD: begin
          rd_q  <= 1'b0;
          pc    <= pc + ADDR_W'(1);
          state <= S_FH_IR;
        end
        S_FH_IR: begin
          ir_hi <= mem_rdata;
          mar   <= pc;
          rd_q  <= 1'b1;
          state <= S_FL_RD;
        end
        S_FL_RD: begin
          rd_q  <= 1'b0;
          pc    <= pc + ADDR_W'(1);
          state <= S_FL_IR;
        end
        S_FL_IR: begin
          ir_lo <= mem_rdata;
          state <= S_DEC;
        end
        S_DEC: begin
          if (dec_legal) begin
            mar   <= dec_addr;
            rd_q  <= 1'b1;
            op_q  <= dec_op;
            state <= S_OP_RD;
          end else begin
            ill_q <= 1'b1;
            state <= S_FH_MAR;
          end
        end
        S_OP_RD: begin
          rd_q  <= 1'b0;
          state <= S_OP_DR;
        end
        S_OP_DR: state <= S_EXE;
        S_EXE: begin
          done_q <= 1'b1;
          state  <= S_FH_MAR;
        end
        default: state <= S_FH_MAR;
      endcase
    end
  end

  assign mem_addr      = mar;
  assign mem_rd        = rd_q;
  assign rf_idx        = dec_ridx;
  assign alu_op        = op_q;
  assign acc           = acc_q;
  assign flags         = flags_q;
  assign instr_done    = done_q;
  assign instr_illegal = ill_q;

endmodule

// File: rtl/acc_seq_core_chk.sv
module acc_seq_core_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic [DATA_W-1:0] acc,
  input logic [2:0]        flags,
  input logic              instr_done,
  input logic              instr_illegal
);
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd); // R2

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> !instr_done); // R5

  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    instr_done |-> !mem_rd); // R5

  AST_FLAGS_ONLY_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    !$stable(flags) |-> instr_done); // R6

  AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    instr_illegal |-> ($stable(acc) && $stable(flags) && !mem_rd)); // R7

  AST_DONE_ILLEGAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(instr_done && instr_illegal)); // R9

endmodule

bind acc_seq_core acc_seq_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_rd        (mem_rd),
  .acc           (acc),
  .flags         (flags),
  .instr_done    (instr_done),
  .instr_illegal (instr_illegal)
);

// File: tb/acc_seq_core_tb.sv
module acc_seq_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NINSTR     = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata;
  logic [3:0]  rf_idx;
  logic [15:0] rf_rdata;
  logic [2:0]  alu_op;
  logic [15:0] acc;
  logic [2:0]  flags;
  logic        instr_done;
  logic        instr_illegal;

  logic [15:0] mem [256];
  logic [15:0] rf  [16];

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_seq_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_rdata(rf_rdata),
    .alu_op(alu_op), .acc(acc), .flags(flags),
    .instr_done(instr_done), .instr_illegal(instr_illegal)
  );

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
  assign rf_rdata = rf[rf_idx];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_hi(int op, int md, int r, logic [19:0] a);
    return {op[4:0], md[2:0], r[3:0], a[19:16]};
  endfunction

  task automatic put(int slot, int op, int md, int r, logic [19:0] a);
    mem[2*slot]   = enc_hi(op, md, r, a);
    mem[2*slot+1] = a[15:0];
  endtask

  initial begin
    logic [19:0] pc_m;
    logic [15:0] exp_acc;
    logic [2:0]  exp_flags;
    mem_rdata = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h0101);
    rf[1] = 16'h7FFF; rf[2] = 16'hFFFF; rf[3] = 16'h0005; rf[4] = 16'h1234;
    rf[5] = 16'hF0F0; rf[6] = 16'h0F00; rf[7] = 16'hAAAA; rf[8] = 16'h0000;
    rf[15] = 16'h0001; rf[0] = 16'h0000;
    mem[8'h80] = 16'h0001; mem[8'h81] = 16'h0001; mem[8'h82] = 16'h0007;
    mem[8'h83] = 16'h1234; mem[8'h84] = 16'h3C3C; mem[8'h85] = 16'h00F0;
    mem[8'h86] = 16'hFFFF; mem[8'h87] = 16'h8001; mem[8'hFF] = 16'h0002;
    put(0, 0, 0, 1, 20'h00080);   // add: sign, no carry
    put(1, 0, 0, 2, 20'hA5081);   // add: zero and carry, high address bits
    put(2, 1, 0, 3, 20'h00082);   // sub: borrow
    put(3, 1, 0, 4, 20'h00083);   // sub: zero
    put(4, 2, 0, 5, 20'h00084);   // and
    put(5, 3, 0, 6, 20'h00085);   // or
    put(6, 4, 0, 7, 20'h00086);   // xor
    put(7, 7, 0, 1, 20'h00080);   // illegal opcode
    put(8, 0, 3, 1, 20'h00080);   // illegal mode
    put(9, 5, 0, 8, 20'h00087);   // move
    put(10, 31, 0, 2, 20'h00081); // illegal opcode
    put(11, 0, 0, 15, 20'hFFFFF); // add at top address
    put(12, 4, 0, 0, 20'h00080);  // xor with zero register

    repeat (3) @(negedge clk);
    chk("R1 reset acc", 32'(acc), 0);
    chk("R1 reset flags", 32'(flags), 0);
    chk("R1 reset alu_op", 32'(alu_op), 0);
    chk("R1 reset read strobe", 32'(mem_rd), 0);
    chk("R1 reset done", 32'(instr_done), 0);
    chk("R1 reset illegal", 32'(instr_illegal), 0);
    rst = 1'b0;

    pc_m = 20'd0;
    exp_acc = '0;
    exp_flags = '0;
    for (int k = 0; k < NINSTR; k++) begin
      logic [15:0] hi, lo, rv, mv, res;
      logic [4:0]  op;
      logic [2:0]  md;
      logic [3:0]  r;
      logic [19:0] ea;
      logic        legal, c;
      int          len;
      hi = mem[pc_m[7:0]];
      lo = mem[pc_m[7:0] + 8'd1];
      op = hi[15:11]; md = hi[10:8]; r = hi[7:4]; ea = {hi[3:0], lo};
      legal = (op < 5'd6) && (md == 3'd0);
      rv = rf[r];
      mv = mem[ea[7:0]];
      c = 1'b0;
      case (op)
        5'd0: begin res = rv + mv; c = ((32'(rv) + 32'(mv)) > 32'hFFFF); end
        5'd1: begin res = rv - mv; c = (rv < mv); end
        5'd2: res = rv & mv;
        5'd3: res = rv | mv;
        5'd4: res = rv ^ mv;
        default: res = mv;
      endcase
      len = legal ? 9 : 6;
      for (int i = 1; i <= len; i++) begin
        logic exp_rd;
        @(negedge clk);
        if (legal && i == 7) exp_acc = rv;
        if (legal && i == 9) begin
          exp_acc = res;
          exp_flags = {c, res[15], (res == 16'h0)};
        end
        exp_rd = (i == 1) || (i == 3) || (legal && i == 6);
        chk("R5/R7 accumulator", 32'(acc), 32'(exp_acc));
        chk("R6 flags", 32'(flags), 32'(exp_flags));
        chk("R2 read strobe", 32'(mem_rd), 32'(exp_rd));
        chk("R5 done pulse", 32'(instr_done), 32'(legal && i == 9));
        chk("R3/R7 illegal pulse", 32'(instr_illegal), 32'(!legal && i == 6));
        chk("R9 done and illegal exclusive", 32'(instr_done & instr_illegal), 0);
        if (i == 1) chk("R8 fetch address", 32'(mem_addr), 32'(pc_m));
        if (i == 3) chk("R2 second word address", 32'(mem_addr), 32'(pc_m + 20'd1));
        if (legal && i == 6) begin
          chk("R4 operand address", 32'(mem_addr), 32'(ea));
          chk("R4 register index", 32'(rf_idx), 32'(r));
        end
        if (legal && i == 9) chk("R5 alu_op", 32'(alu_op), 32'(op[2:0]));
      end
      pc_m = pc_m + 20'd2;
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule